// File: doc/BRIEF.md
# Key Source Selection and Protection Controller

This block decides where the key of a cipher core comes from and protects the key registers. In the default mode, software builds the key in two share registers. It writes them one data word at a time, and the core key is the XOR of the two shares. When the sideload control bit is set, the core takes its key from a key manager instead. That key arrives on a dedicated input with a valid flag. In this mode, software writes to the share registers are dropped without any error.

A start request reaches the core only when four things hold:
- the core reports idle;
- no wipe is in progress;
- in sideload mode, the key manager's valid flag is high;
- otherwise the mode does not restrict the request.

When a start is accepted in sideload mode, the sideload key is copied into an internal register. Changes on the sideload input after that do not disturb the message in progress. The control bit can only be changed while the core is idle. To move to a new sideload key, software waits for idle, waits for the key manager to present the new key with valid high, and then writes the control bit again. A one-cycle wipe command clears both shares and the latched sideload copy, and is acknowledged by a one-cycle done pulse.

Top module: `skc_top`

## Requirements
- R1: After reset the control bit is 0 (software mode), both shares and the sideload copy are zero, `core_key_o` is zero, and `core_start_o` and `wipe_done_o` are low.
- R2: In software mode, a key write loads `key_wr_data_i` into word `key_wr_idx_i` of share `key_wr_share_i` (0 or 1) on the next clock edge. Word i occupies bits [i*DATA_W +: DATA_W]. `core_key_o` equals share0 XOR share1.
- R3: While the control bit is 1, key writes change neither share. This is observable through `core_key_o` after returning to software mode.
- R4: A write of `ctrl_wr_val_i` to the control bit takes effect only if `core_idle_i` is 1 in that cycle; otherwise the bit keeps its value. `sideload_mode_o` shows the bit.
- R5: `core_start_o` rises one cycle after a `start_req_i` that meets all of these: `core_idle_i` is 1, and in sideload mode `sl_valid_i` is 1. In every other case it stays low.
- R6: In software mode, `sl_valid_i` has no influence on whether a start is passed on.
- R7: In sideload mode, `core_key_o` shows the sideload key captured at the last accepted start. Later changes of `sl_key_i` or `sl_valid_i` leave it unchanged.
- R8: A `wipe_i` cycle clears both shares and the sideload copy on the next edge, taking priority over a key write in the same cycle. It makes `wipe_done_o` high for exactly the following cycle, and blocks a start request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Write strobe for the sideload control bit |
| ctrl_wr_val_i | input | 1 | Value written to the control bit |
| key_wr_i | input | 1 | Key share word write strobe |
| key_wr_share_i | input | 1 | Share select (0 or 1) |
| key_wr_idx_i | input | IDX_W | Word index within the share |
| key_wr_data_i | input | DATA_W | Word data |
| start_req_i | input | 1 | Start request from the control side |
| core_idle_i | input | 1 | Core reports idle |
| sl_key_i | input | KEY_W | Sideload key from the key manager |
| sl_valid_i | input | 1 | Sideload key valid |
| wipe_i | input | 1 | Wipe command for all key registers |
| sideload_mode_o | output | 1 | Current value of the control bit |
| core_start_o | output | 1 | Start pulse to the core |
| core_key_o | output | KEY_W | Key presented to the core |
| wipe_done_o | output | 1 | One-cycle wipe acknowledge |

## Verification
The bench builds the block with KEY_W = 64 and DATA_W = 16, so each share has four words and a two-bit index. This keeps every word of both shares small enough to be tracked by a plain reference model. With only four words per share, the table of writes reaches every word index and both shares, including overwrites and bits that cancel in the XOR. The same small key lets the directed part compare the whole key after each wipe, write-blocking and latching scenario.

// File: rtl/skc_pkg.sv
package skc_pkg;

  typedef enum logic {
    SRC_SOFT = 1'b0,
    SRC_SIDE = 1'b1
  } key_src_e;

  function automatic int unsigned idx_width(input int unsigned words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction

endpackage

// File: rtl/skc_share_bank.sv
module skc_share_bank #(
  parameter int unsigned KEY_W  = 128,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = KEY_W / DATA_W,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_share_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lock_i,
  input  logic              wipe_i,
  output logic [KEY_W-1:0]  key_o
);

  logic [1:0][WORDS-1:0][DATA_W-1:0] share_q, share_d;
  logic [1:0][WORDS-1:0]             word_we;
  logic                              wr_ok;

  assign wr_ok = wr_en_i && !lock_i && !wipe_i;

  for (genvar s = 0; s < 2; s++) begin : g_share
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign word_we[s][w] = wr_ok && (wr_share_i == s[0]) &&
                             (wr_idx_i == IDX_W'(w));
    end
  end

  always_comb begin
    share_d = share_q;
    if (wipe_i) begin
      share_d = '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (word_we[s][w]) share_d[s][w] = wr_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      share_q <= '0;
    end else if (wipe_i || wr_ok) begin
      share_q <= share_d;
    end
  end

  assign key_o = KEY_W'(share_q[0]) ^ KEY_W'(share_q[1]);

  AST_SHARES_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !wipe_i) |=> $stable(share_q)); // R3

  AST_SHARES_WIPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> (share_q == '0)); // R8

endmodule

// File: rtl/skc_sl_latch.sv
module skc_sl_latch #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             wipe_i,
  input  logic [KEY_W-1:0] sl_key_i,
  output logic [KEY_W-1:0] key_o
);

  logic [KEY_W-1:0] copy_q, copy_d;
  logic             copy_en;

  assign copy_en = capture_i || wipe_i;

  always_comb begin
    copy_d = copy_q;
    if (wipe_i)         copy_d = '0;
    else if (capture_i) copy_d = sl_key_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      copy_q <= '0;
    end else if (copy_en) begin
      copy_q <= copy_d;
    end
  end

  assign key_o = copy_q;

  AST_COPY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !wipe_i) |=> $stable(copy_q)); // R7

  AST_COPY_WIPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> (copy_q == '0)); // R8

endmodule

// File: rtl/skc_ctrl.sv
module skc_ctrl
  import skc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_wr_val_i,
  input  logic core_idle_i,
  input  logic start_req_i,
  input  logic sl_valid_i,
  input  logic wipe_i,
  output logic mode_o,
  output logic capture_o,
  output logic start_o,
  output logic wipe_done_o
);

  key_src_e src_q, src_d;
  logic     start_q, start_d;
  logic     done_q, done_d;
  logic     ctrl_en;
  logic     key_ready;

  assign ctrl_en = ctrl_wr_i && core_idle_i;

  always_comb begin
    src_d = src_q;
    if (ctrl_en) src_d = ctrl_wr_val_i ? SRC_SIDE : SRC_SOFT;
  end

  assign key_ready = (src_q == SRC_SOFT) || sl_valid_i;
  assign start_d   = start_req_i && core_idle_i && !wipe_i && key_ready;
  assign done_d    = wipe_i;
  assign capture_o = start_d && (src_q == SRC_SIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_SOFT;
    end else if (ctrl_en) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign mode_o      = (src_q == SRC_SIDE);
  assign start_o     = start_q;
  assign wipe_done_o = done_q;

  AST_MODE_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_idle_i |=> $stable(mode_o)); // R4

  AST_NO_START_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_i && mode_o && !sl_valid_i) |=> !start_o); // R5

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_idle_i |=> !start_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> wipe_done_o); // R8

  AST_NO_START_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> !start_o); // R8

endmodule

// File: rtl/skc_top.sv
module skc_top
  import skc_pkg::*;
#(
  parameter int unsigned KEY_W  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORDS = KEY_W / DATA_W,
  localparam int unsigned IDX_W = skc_pkg::idx_width(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_wr_val_i,
  input  logic              key_wr_i,
  input  logic              key_wr_share_i,
  input  logic [IDX_W-1:0]  key_wr_idx_i,
  input  logic [DATA_W-1:0] key_wr_data_i,
  input  logic              start_req_i,
  input  logic              core_idle_i,
  input  logic [KEY_W-1:0]  sl_key_i,
  input  logic              sl_valid_i,
  input  logic              wipe_i,
  output logic              sideload_mode_o,
  output logic              core_start_o,
  output logic [KEY_W-1:0]  core_key_o,
  output logic              wipe_done_o
);

  logic             mode;
  logic             capture;
  logic [KEY_W-1:0] soft_key;
  logic [KEY_W-1:0] side_key;

  skc_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wr_val_i(ctrl_wr_val_i),
    .core_idle_i  (core_idle_i),
    .start_req_i  (start_req_i),
    .sl_valid_i   (sl_valid_i),
    .wipe_i       (wipe_i),
    .mode_o       (mode),
    .capture_o    (capture),
    .start_o      (core_start_o),
    .wipe_done_o  (wipe_done_o)
  );

  skc_share_bank #(
    .KEY_W (KEY_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS),
    .IDX_W (IDX_W)
  ) i_shares (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (key_wr_i),
    .wr_share_i(key_wr_share_i),
    .wr_idx_i  (key_wr_idx_i),
    .wr_data_i (key_wr_data_i),
    .lock_i    (mode),
    .wipe_i    (wipe_i),
    .key_o     (soft_key)
  );

  skc_sl_latch #(
    .KEY_W(KEY_W)
  ) i_sl_copy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .wipe_i   (wipe_i),
    .sl_key_i (sl_key_i),
    .key_o    (side_key)
  );

  assign sideload_mode_o = mode;
  assign core_key_o      = mode ? side_key : soft_key;

  AST_SIDE_KEY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode && !start_req_i && !wipe_i && !ctrl_wr_i) |=> $stable(core_key_o)); // R7

endmodule

// File: tb/test_skc_top.sv
module test_skc_top;

  localparam int unsigned KW = 64;
  localparam int unsigned DW = 16;
  localparam int unsigned NW = KW / DW;
  localparam int unsigned IW = 2;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          ctrl_wr, ctrl_val, key_wr, key_share;
  logic [IW-1:0] key_idx;
  logic [DW-1:0] key_data;
  logic          start_req, core_idle, sl_valid, wipe;
  logic [KW-1:0] sl_key;
  logic          mode_o, start_o, done_o;
  logic [KW-1:0] key_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [1:0][NW-1:0][DW-1:0] mdl;

  always #2 clk = ~clk;

  skc_top #(.KEY_W(KW), .DATA_W(DW)) i_skc_top (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctrl_wr_i(ctrl_wr), .ctrl_wr_val_i(ctrl_val),
    .key_wr_i(key_wr), .key_wr_share_i(key_share),
    .key_wr_idx_i(key_idx), .key_wr_data_i(key_data),
    .start_req_i(start_req), .core_idle_i(core_idle),
    .sl_key_i(sl_key), .sl_valid_i(sl_valid), .wipe_i(wipe),
    .sideload_mode_o(mode_o), .core_start_o(start_o),
    .core_key_o(key_o), .wipe_done_o(done_o)
  );

  // {share, index, data}
  localparam logic [18:0] WR_TAB [8] = '{
    {1'b0, 2'd0, 16'h1234}, {1'b0, 2'd1, 16'hABCD},
    {1'b0, 2'd2, 16'h0F0F}, {1'b0, 2'd3, 16'h8001},
    {1'b1, 2'd0, 16'h1234}, {1'b1, 2'd3, 16'hFFFF},
    {1'b1, 2'd2, 16'h00F0}, {1'b0, 2'd1, 16'h5555}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] mdl_key();
    return KW'(mdl[0]) ^ KW'(mdl[1]);
  endfunction

  task automatic key_write(input logic s, input logic [IW-1:0] i, input logic [DW-1:0] d);
    key_wr = 1'b1; key_share = s; key_idx = i; key_data = d;
    tick();
    key_wr = 1'b0;
  endtask

  task automatic set_mode(input logic v, input logic idle);
    ctrl_wr = 1'b1; ctrl_val = v; core_idle = idle;
    tick();
    ctrl_wr = 1'b0; core_idle = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; ctrl_wr = 0; ctrl_val = 0; key_wr = 0; key_share = 0;
    key_idx = '0; key_data = '0; start_req = 0; core_idle = 1; sl_valid = 0;
    wipe = 0; sl_key = '0; mdl = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 key", key_o, '0);
    chk("R1 mode", KW'(mode_o), '0);
    chk("R1 start", KW'(start_o), '0);
    chk("R1 done", KW'(done_o), '0);

    // R2 table of share writes
    for (int k = 0; k < 8; k++) begin
      key_write(WR_TAB[k][18], WR_TAB[k][17:16], WR_TAB[k][15:0]);
      mdl[WR_TAB[k][18]][WR_TAB[k][17:16]] = WR_TAB[k][15:0];
      chk($sformatf("R2 write %0d", k), key_o, mdl_key());
    end

    // R6 software mode start ignores valid
    sl_valid = 0; start_req = 1; tick(); start_req = 0;
    chk("R6 start with valid low", KW'(start_o), 64'd1);
    tick();
    chk("R5 start is one pulse", KW'(start_o), '0);
    // R5 busy core blocks start
    core_idle = 0; start_req = 1; tick(); start_req = 0; core_idle = 1;
    chk("R5 start while busy", KW'(start_o), '0);

    // R4 control write ignored while busy
    set_mode(1'b1, 1'b0);
    chk("R4 busy write dropped", KW'(mode_o), '0);
    set_mode(1'b1, 1'b1);
    chk("R4 idle write accepted", KW'(mode_o), 64'd1);
    chk("R7 copy empty before start", key_o, '0);

    // R3 write attempt in sideload mode
    key_write(1'b0, 2'd1, 16'hDEAD);

    // R5 no start without valid
    sl_key = 64'hA5A5_0000_1111_2222;
    start_req = 1; tick(); start_req = 0;
    chk("R5 start without valid", KW'(start_o), '0);
    chk("R7 no capture without valid", key_o, '0);

    // R5/R7 start with valid captures key
    sl_valid = 1; start_req = 1; tick(); start_req = 0;
    chk("R5 start with valid", KW'(start_o), 64'd1);
    chk("R7 captured key", key_o, 64'hA5A5_0000_1111_2222);
    sl_key = 64'h0123_4567_89AB_CDEF; sl_valid = 0;
    tick();
    chk("R7 input change ignored", key_o, 64'hA5A5_0000_1111_2222);

    // R3 back to software mode: shares untouched
    set_mode(1'b0, 1'b1);
    chk("R3 shares unchanged", key_o, mdl_key());

    // R8 wipe beats a write and blocks start
    wipe = 1; key_wr = 1; key_share = 1; key_idx = 2'd0; key_data = 16'h7777;
    start_req = 1;
    tick();
    wipe = 0; key_wr = 0; start_req = 0;
    chk("R8 shares cleared", key_o, '0);
    chk("R8 done pulse", KW'(done_o), 64'd1);
    chk("R8 start blocked", KW'(start_o), '0);
    tick();
    chk("R8 done one cycle", KW'(done_o), '0);
    set_mode(1'b1, 1'b1);
    chk("R8 copy cleared", key_o, '0);

    finish_run();
  end

endmodule